// File: doc/BRIEF.md
# Loopback and Loss-of-Signal Path Selector

This block models the bit-level data routing of a 16:1 line transceiver. Each transmit word is serialized most significant bit first onto a serial output. A serial receive stream is gathered back into words, and its first bit lands in the top bit. Two independent loopback controls steer the serial and parallel paths. Facility loopback turns the line input straight back onto the line output. Equipment loopback feeds the serializer back into the deserializer. With both set, the block runs a split loopback. All paths share one bit clock. Clock routing is reported on two source-select outputs, which tell the surrounding clock tree where the transmit clock and the receive word clocks come from.

A line-fault input is compared against a polarity input. When the two differ, the words gathered from the line are forced to zero. A loop-timing request is passed on only while equipment loopback is off. Two receive word clocks come from the bit counter: one at divide-by-16, and one that can be set to divide-by-16 or divide-by-32. Mode, fault and loop-timing requests are sampled only at word boundaries, so no word is ever built from two modes.

Top module: `lpbk_path_sel`

## Requirements
- R1: `tx_load_o` is high in the last bit cycle of each 16-cycle word slot. The `tx_word_i` value present at the end of that cycle is sent on `tx_ser_o` during the next slot, bit 15 first and bit 0 last.
- R2: The deserializer places the first bit of a slot into bit 15. The finished word appears on `rx_word_o` at the first cycle of the following slot. `rx_word_vld_o` is high for that one cycle and low otherwise. `rx_word_o` holds its value between updates.
- R3: With facility loopback, `tx_ser_o` follows `rx_ser_i` and `tx_clk_from_rx_o` is 1. The line input is still deserialized onto `rx_word_o`.
- R4: With equipment loopback, the word sent in a slot is delivered on `rx_word_o` one slot later and `rx_clk_from_tx_o` is 1. `tx_ser_o` still carries the serialized word unless facility loopback is also set.
- R5: With both loopbacks set, `tx_ser_o` follows `rx_ser_i` and `rx_word_o` returns the transmit words. Both clock-source outputs are 1.
- R6: Loss of signal is active when `los_i` differs from `los_pol_i`, and `los_active_o` shows it. While it is active and equipment loopback is off, the delivered word is all zeros. Normal words return once the two pins match.
- R7: `loop_tim1_eff_o` equals the loop-timing request, but is forced to 0 whenever equipment loopback is active.
- R8: `rx_clk2_o` runs at divide-by-32 (bit 4 of the bit count since reset) when `rx_clk2_sel_i` is 0. It runs at divide-by-16 (bit 3) when `rx_clk2_sel_i` is 1.
- R9: `rx_clk16_o` is bit 3 of the bit count since reset, so it falls at every word boundary.
- R10: Changes to the loopback, fault, polarity or loop-timing inputs in the middle of a slot have no effect until the next word boundary.
- R11: During and right after reset, `rx_word_o` is 0, `tx_ser_o` is 0, both word clocks are 0 and all mode outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word_i | input | 16 | Parallel transmit word |
| tx_load_o | output | 1 | Transmit word is taken at the end of this cycle |
| fac_loop_i | input | 1 | Facility loopback request |
| equ_loop_i | input | 1 | Equipment loopback request |
| los_i | input | 1 | Line fault pin from the optics |
| los_pol_i | input | 1 | Level of `los_i` that means the signal is present |
| loop_tim1_i | input | 1 | Loop-timing request |
| rx_clk2_sel_i | input | 1 | Second word clock rate: 0 divide-by-32, 1 divide-by-16 |
| rx_ser_i | input | 1 | Serial line receive bit |
| tx_ser_o | output | 1 | Serial line transmit bit |
| tx_clk_from_rx_o | output | 1 | Transmit clock is taken from the receive clock |
| rx_word_o | output | 16 | Parallel receive word |
| rx_word_vld_o | output | 1 | New receive word this cycle |
| rx_clk16_o | output | 1 | Receive word clock, divide-by-16 |
| rx_clk2_o | output | 1 | Receive word clock, divide-by-16 or divide-by-32 |
| rx_clk_from_tx_o | output | 1 | Receive word clocks are taken from the transmit clock |
| loop_tim1_eff_o | output | 1 | Loop timing in force |
| los_active_o | output | 1 | Loss of signal latched for this slot |

## Verification
A slip in the bit counter moves `tx_load_o`, the valid pulse and both word clocks within the same cycle. It also rotates every delivered word one slot later. A wrong latched mode shows up on `tx_ser_o` in the first bit cycle of the slot, and on the clock-source outputs at the same time. A mistake in the shift order or in the fault gating stays hidden until the word is delivered, one slot after its bits were sent. The bench therefore compares every bit cycle and every delivered word for all four loopback settings and all four fault-pin settings.

// File: rtl/lpbk_pkg.sv
`timescale 1ns/1ps
package lpbk_pkg;
  // Mode snapshot taken at each word boundary.
  typedef struct packed {
    logic fac;  // line input turned back to line output
    logic equ;  // serializer fed back into deserializer
    logic los;  // loss of signal in force
    logic lt;   // loop timing in force
  } route_t;

  // Loss of signal when the fault pin and its polarity pin disagree.
  function automatic logic los_from_pins(input logic los, input logic pol);
    return los ^ pol;
  endfunction

  // Loop timing is blocked while the internal clock loops back to itself.
  function automatic logic lt_allowed(input logic req, input logic equ);
    return req & ~equ;
  endfunction

  // Second word clock tap: 1 picks the short divider, 0 the long one.
  function automatic logic clk_pick(input logic d16, input logic d32, input logic sel);
    return sel ? d16 : d32;
  endfunction
endpackage

// File: rtl/lpbk_word_timer.sv
`timescale 1ns/1ps
module lpbk_word_timer #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic bnd_o,
  output logic div_w_o,
  output logic div_2w_o
);
  localparam int CW = $clog2(W);
  logic [CW:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign bnd_o    = (cnt_q[CW-1:0] == CW'(W - 1));
  assign div_w_o  = cnt_q[CW-1];
  assign div_2w_o = cnt_q[CW];
endmodule

// File: rtl/lpbk_serializer.sv
`timescale 1ns/1ps
module lpbk_serializer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sh_q <= '0;
    else if (load_i) sh_q <= word_i;
    else             sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign bit_o = sh_q[W-1];
endmodule

// File: rtl/lpbk_deserializer.sv
`timescale 1ns/1ps
module lpbk_deserializer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  input  logic         capture_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);
  logic [W-1:0] ds_q;
  logic [W-1:0] word_q;
  logic         vld_q;
  logic [W-1:0] next_w;

  assign next_w = {ds_q[W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ds_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      ds_q  <= next_w;
      vld_q <= capture_i;
      if (capture_i) word_q <= next_w;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/lpbk_path_sel.sv
`timescale 1ns/1ps
module lpbk_path_sel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_word_i,
  output logic         tx_load_o,
  input  logic         fac_loop_i,
  input  logic         equ_loop_i,
  input  logic         los_i,
  input  logic         los_pol_i,
  input  logic         loop_tim1_i,
  input  logic         rx_clk2_sel_i,
  input  logic         rx_ser_i,
  output logic         tx_ser_o,
  output logic         tx_clk_from_rx_o,
  output logic [W-1:0] rx_word_o,
  output logic         rx_word_vld_o,
  output logic         rx_clk16_o,
  output logic         rx_clk2_o,
  output logic         rx_clk_from_tx_o,
  output logic         loop_tim1_eff_o,
  output logic         los_active_o
);
  import lpbk_pkg::*;

  // Named internal events for the checker.
  logic   bnd;
  logic   div_w;
  logic   div_2w;
  logic   ser_bit;
  logic   line_bit;
  logic   des_bit;
  route_t req;
  route_t mode_q;

  lpbk_word_timer #(.W(W)) timer_i (
    .clk(clk), .rst_n(rst_n), .bnd_o(bnd), .div_w_o(div_w), .div_2w_o(div_2w)
  );

  assign req.fac = fac_loop_i;
  assign req.equ = equ_loop_i;
  assign req.los = los_from_pins(los_i, los_pol_i);
  assign req.lt  = lt_allowed(loop_tim1_i, equ_loop_i);

  always_ff @(posedge clk) begin
    if (!rst_n)   mode_q <= '0;
    else if (bnd) mode_q <= req;
  end

  lpbk_serializer #(.W(W)) ser_i (
    .clk(clk), .rst_n(rst_n), .load_i(bnd), .word_i(tx_word_i), .bit_o(ser_bit)
  );

  assign line_bit = mode_q.equ ? ser_bit : rx_ser_i;
  assign des_bit  = (!mode_q.equ && mode_q.los) ? 1'b0 : line_bit;

  lpbk_deserializer #(.W(W)) des_i (
    .clk(clk), .rst_n(rst_n), .bit_i(des_bit), .capture_i(bnd),
    .word_o(rx_word_o), .vld_o(rx_word_vld_o)
  );

  assign tx_load_o        = bnd;
  assign tx_ser_o         = mode_q.fac ? rx_ser_i : ser_bit;
  assign tx_clk_from_rx_o = mode_q.fac;
  assign rx_clk_from_tx_o = mode_q.equ;
  assign loop_tim1_eff_o  = mode_q.lt;
  assign los_active_o     = mode_q.los;
  assign rx_clk16_o       = div_w;
  assign rx_clk2_o        = clk_pick(div_w, div_2w, rx_clk2_sel_i);
endmodule

// File: rtl/lpbk_path_sel_chk.sv
`timescale 1ns/1ps
module lpbk_path_sel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bnd,
  input logic         ser_bit,
  input logic         rx_ser_i,
  input logic         tx_ser_o,
  input logic         tx_clk_from_rx_o,
  input logic         rx_clk_from_tx_o,
  input logic         loop_tim1_eff_o,
  input logic         los_active_o,
  input logic [W-1:0] rx_word_o,
  input logic         rx_word_vld_o,
  input logic         rx_clk16_o
);
  assert_lt_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(loop_tim1_eff_o && rx_clk_from_tx_o));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> ($stable(tx_clk_from_rx_o) && $stable(rx_clk_from_tx_o) &&
              $stable(los_active_o) && $stable(loop_tim1_eff_o)));

  assert_fac_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clk_from_rx_o |-> (tx_ser_o == rx_ser_i));

  assert_equ_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clk_from_tx_o && !tx_clk_from_rx_o) |-> (tx_ser_o == ser_bit));

  assert_los_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && los_active_o && !rx_clk_from_tx_o) |=> (rx_word_o == '0));

  assert_vld_after_bnd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> rx_word_vld_o);

  assert_vld_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_vld_o |=> !rx_word_vld_o);

  assert_word_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(rx_word_o));

  assert_clk16_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> !rx_clk16_o);
endmodule

bind lpbk_path_sel lpbk_path_sel_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bnd(bnd), .ser_bit(ser_bit), .rx_ser_i(rx_ser_i),
  .tx_ser_o(tx_ser_o), .tx_clk_from_rx_o(tx_clk_from_rx_o),
  .rx_clk_from_tx_o(rx_clk_from_tx_o), .loop_tim1_eff_o(loop_tim1_eff_o),
  .los_active_o(los_active_o), .rx_word_o(rx_word_o),
  .rx_word_vld_o(rx_word_vld_o), .rx_clk16_o(rx_clk16_o)
);

// File: tb/lpbk_path_sel_tb.sv
`timescale 1ns/1ps
module lpbk_path_sel_tb_top;
  localparam int NS = 19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tx_word_i;
  logic        tx_load_o, fac_loop_i, equ_loop_i, los_i, los_pol_i;
  logic        loop_tim1_i, rx_clk2_sel_i, rx_ser_i, tx_ser_o, tx_clk_from_rx_o;
  logic [15:0] rx_word_o;
  logic        rx_word_vld_o, rx_clk16_o, rx_clk2_o, rx_clk_from_tx_o;
  logic        loop_tim1_eff_o, los_active_o;

  always #2.5 clk = ~clk;

  lpbk_path_sel #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_word_i(tx_word_i), .tx_load_o(tx_load_o),
    .fac_loop_i(fac_loop_i), .equ_loop_i(equ_loop_i), .los_i(los_i),
    .los_pol_i(los_pol_i), .loop_tim1_i(loop_tim1_i), .rx_clk2_sel_i(rx_clk2_sel_i),
    .rx_ser_i(rx_ser_i), .tx_ser_o(tx_ser_o), .tx_clk_from_rx_o(tx_clk_from_rx_o),
    .rx_word_o(rx_word_o), .rx_word_vld_o(rx_word_vld_o), .rx_clk16_o(rx_clk16_o),
    .rx_clk2_o(rx_clk2_o), .rx_clk_from_tx_o(rx_clk_from_tx_o),
    .loop_tim1_eff_o(loop_tim1_eff_o), .los_active_o(los_active_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] txw [0:NS];
  logic [15:0] rxw [0:NS];
  bit fac_a [0:NS];
  bit equ_a [0:NS];
  bit los_a [0:NS];
  bit pol_a [0:NS];
  bit lt_a  [0:NS];
  bit sel_a [0:NS];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_word(input int s);
    if (equ_a[s])                return txw[s];
    else if (los_a[s] ^ pol_a[s]) return 16'h0000;
    else                          return rxw[s];
  endfunction

  task automatic apply_cfg(input int s);
    tx_word_i     = txw[s];
    fac_loop_i    = fac_a[s];
    equ_loop_i    = equ_a[s];
    los_i         = los_a[s];
    los_pol_i     = pol_a[s];
    loop_tim1_i   = lt_a[s];
    rx_clk2_sel_i = sel_a[s];
  endtask

  initial begin
    // Slots 0..15 sweep the four loopback settings against the four fault-pin settings.
    for (int s = 0; s <= NS; s++) begin
      logic [15:0] v;
      v = 16'(s * 16'h3B1D) ^ 16'hA5A5;
      txw[s]   = v;
      rxw[s]   = {v[7:0], v[15:8]} ^ 16'h0FF0;
      fac_a[s] = s[0];
      equ_a[s] = s[1];
      los_a[s] = s[2];
      pol_a[s] = s[3];
      lt_a[s]  = s[0] ^ s[2] ^ s[4];
      sel_a[s] = s[1] ^ s[3];
    end
    txw[17] = 16'hFFFF; rxw[17] = 16'h8000;
    txw[18] = 16'h0001; rxw[18] = 16'hFFFF;

    rst_n = 1'b0;
    tx_word_i = '0; fac_loop_i = 0; equ_loop_i = 0; los_i = 0; los_pol_i = 0;
    loop_tim1_i = 0; rx_clk2_sel_i = 0; rx_ser_i = 0;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(rx_word_o == 16'h0, "R11 rx_word in reset", 32'(rx_word_o), 0);
    chk(tx_ser_o == 1'b0, "R11 tx_ser in reset", 32'(tx_ser_o), 0);
    chk({rx_clk16_o, rx_clk2_o} == 2'b00, "R11 word clocks in reset", 32'({rx_clk16_o, rx_clk2_o}), 0);
    chk({tx_clk_from_rx_o, rx_clk_from_tx_o, loop_tim1_eff_o, los_active_o, rx_word_vld_o} == 5'b0,
        "R11 mode outputs in reset",
        32'({tx_clk_from_rx_o, rx_clk_from_tx_o, loop_tim1_eff_o, los_active_o, rx_word_vld_o}), 0);
    rst_n = 1'b1;

    for (int c = 0; c <= 16 * (NS + 2); c++) begin
      int s;
      int k;
      s = c / 16 - 1;
      k = c % 16;
      // drive
      rx_ser_i = (s >= 0 && s <= NS) ? rxw[s][15-k] : 1'b0;
      if (k == 15 && s + 1 <= NS) apply_cfg(s + 1);
      if (s >= 0 && s <= NS && (s % 5) == 2 && k == 6) begin
        fac_loop_i = ~fac_a[s]; equ_loop_i = ~equ_a[s];
        los_i = ~los_a[s]; loop_tim1_i = ~lt_a[s];
      end
      if (s >= 0 && s <= NS && (s % 5) == 2 && k == 9) apply_cfg(s);
      #1;
      // delivered word and valid pulse (R2, R3, R4, R5, R6)
      if (k == 0) begin
        logic [15:0] e;
        e = (s <= 0) ? 16'h0000 : exp_word(s - 1);
        chk(rx_word_vld_o == (c != 0), "R2 valid at slot start", 32'(rx_word_vld_o), 32'(c != 0));
        if (s >= 1 && equ_a[s-1] && fac_a[s-1])
          chk(rx_word_o == e, "R5 split loop word", 32'(rx_word_o), 32'(e));
        else if (s >= 1 && equ_a[s-1])
          chk(rx_word_o == e, "R4 equipment loop word", 32'(rx_word_o), 32'(e));
        else if (s >= 1 && (los_a[s-1] ^ pol_a[s-1]))
          chk(rx_word_o == e, "R6 zero word on loss of signal", 32'(rx_word_o), 32'(e));
        else if (s >= 1 && fac_a[s-1])
          chk(rx_word_o == e, "R3 line word during facility loop", 32'(rx_word_o), 32'(e));
        else
          chk(rx_word_o == e, "R2 line word msb first", 32'(rx_word_o), 32'(e));
      end else begin
        chk(rx_word_vld_o == 1'b0, "R2 valid low mid slot", 32'(rx_word_vld_o), 0);
      end
      if (s <= NS) begin
        chk(tx_load_o == (k == 15), "R1 load strobe", 32'(tx_load_o), 32'(k == 15));
        // R9, R8: word clocks from the cycle count
        chk(rx_clk16_o == 1'((c >> 3) & 1), "R9 divide-by-16 clock", 32'(rx_clk16_o), 32'((c >> 3) & 1));
        chk(rx_clk2_o == (rx_clk2_sel_i ? 1'((c >> 3) & 1) : 1'((c >> 4) & 1)), "R8 second word clock",
            32'(rx_clk2_o), 32'(rx_clk2_sel_i ? ((c >> 3) & 1) : ((c >> 4) & 1)));
      end
      if (s == -1) begin
        chk(tx_ser_o == 1'b0, "R11 tx_ser idle after reset", 32'(tx_ser_o), 0);
      end else if (s <= NS) begin
        logic eb;
        eb = fac_a[s] ? rxw[s][15-k] : txw[s][15-k];
        chk(tx_ser_o == eb, fac_a[s] ? "R3 facility serial out" : "R1 serial out msb first",
            32'(tx_ser_o), 32'(eb));
        chk(tx_clk_from_rx_o == fac_a[s], (k >= 6 && k <= 9) ? "R10 facility held mid slot" : "R3 tx clock source",
            32'(tx_clk_from_rx_o), 32'(fac_a[s]));
        chk(rx_clk_from_tx_o == equ_a[s], (k >= 6 && k <= 9) ? "R10 equipment held mid slot" : "R4 rx clock source",
            32'(rx_clk_from_tx_o), 32'(equ_a[s]));
        chk(los_active_o == (los_a[s] ^ pol_a[s]), "R6 loss of signal flag",
            32'(los_active_o), 32'(los_a[s] ^ pol_a[s]));
        chk(loop_tim1_eff_o == (lt_a[s] & ~equ_a[s]), "R7 loop timing gate",
            32'(loop_tim1_eff_o), 32'(lt_a[s] & ~equ_a[s]));
      end
      @(negedge clk);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule